// File: doc/BRIEF.md
# Watchdog Timer with Keyed Stop

This block is a watchdog counter that is already running when reset is released. If software never services it, the counter overflows and the block drives a system-reset pulse. Software reaches the block through a small 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Software can reload the counter through a trigger register. It can halt the counter only by sending an ordered pair of key values to the control register. A second key pair starts it again. Nothing else stops the count. There is no enable bit, and no clock gating outside the key sequence halts it.

Writes to the control and trigger registers are posted. Each accepted write raises a pending bit in the status register for a fixed number of cycles, and the write acts on the counter logic when that bit drops. Software must poll the pending bit and wait for it to clear before sending the next key. A control write that arrives while its pending bit is set is discarded.

The key tracker has four named states. RUN means counting with no key seen. ARMED means counting after the first stop key. HALT means stopped. REARM means stopped after the first restart key. The transitions are:
- RUN goes to ARMED on 0xAAAA.
- ARMED goes to HALT on 0x5555.
- HALT goes to REARM on 0xBBBB.
- REARM goes to RUN on 0x4444.
- In the two counting states, any other applied value returns the tracker to RUN.
- In the two stopped states, any other applied value returns the tracker to HALT.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the counter runs. The count (0x28) and the load register (0x2C) both read LOAD_INIT (0xFFFF_FF00 by default). The control register (0x48) reads 0, and the status register (0x34) reads 0.
- R2: While the counter runs, it adds one every DIV clocks (default 2). When it steps from all-ones it reloads from the load register, and sys_rst_out goes high for exactly RST_CYC (16) cycles.
- R3: An accepted write to 0x48 sets status bit 4 (mask 0x10) for exactly SYNC_CYC (3) cycles. The value takes effect in the key tracker on the clock edge where the bit clears.
- R4: A write to 0x48 while status bit 4 is set is discarded. The readback, the pending timing and the tracker state are all unchanged.
- R5: Applying 0x0000AAAA and then 0x0000_5555 as the next applied control value halts the counter. While halted, the count holds and no reset pulse starts.
- R6: Any applied control value other than the expected next key returns the tracker to RUN (while counting) or HALT (while stopped). A 0x5555 that is not directly preceded by 0xAAAA leaves the counter running.
- R7: Applying 0xBBBB and then 0x4444 to a halted counter restarts it from the value it held.
- R8: A write of any value to 0x30 sets status bit 3 (mask 0x08) for exactly 3 cycles. When the bit clears, the counter reloads from the load register and the divider phase restarts.
- R9: The load register at 0x2C is read/write and takes effect at once. The running count reads at 0x28, and any unmapped address reads 0.
- R10: Reading 0x48 returns the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_out | output | 1 | System-reset pulse on counter overflow |

## Verification
Checked on every cycle by assertions:
- the reset pulse never lasts longer or shorter than its set length;
- the pending bit of the control register never stays up past the synchroniser delay;
- a discarded write leaves the readback unchanged;
- a halted counter holds its value unless a trigger reload lands;
- counting stops only on an applied 0x5555 and resumes only on an applied 0x4444.

Only the bench scenarios can show the key orderings as a whole, because each of these needs a history of several writes:
- a stop key that is ignored after a wrong value;
- a second key lost because it arrived while the pending bit was set;
- the trigger reload;
- restart from the held count;
- a full silent overflow period while halted.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        KS_RUN   = 2'd0,
        KS_ARMED = 2'd1,
        KS_HALT  = 2'd2,
        KS_REARM = 2'd3
    } kstate_t;

    localparam logic [7:0] A_COUNT = 8'h28;
    localparam logic [7:0] A_LOAD  = 8'h2C;
    localparam logic [7:0] A_TRIG  = 8'h30;
    localparam logic [7:0] A_PEND  = 8'h34;
    localparam logic [7:0] A_CTRL  = 8'h48;

    localparam logic [31:0] KEY_STOP1 = 32'h0000_AAAA;
    localparam logic [31:0] KEY_STOP2 = 32'h0000_5555;
    localparam logic [31:0] KEY_GO1   = 32'h0000_BBBB;
    localparam logic [31:0] KEY_GO2   = 32'h0000_4444;

    localparam int PEND_CTRL_BIT = 4;
    localparam int PEND_TRIG_BIT = 3;

endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
    parameter int SYNC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic accept,
    output logic busy,
    output logic apply
);
    localparam int CW = $clog2(SYNC_CYC + 1);

    logic [CW-1:0] left_q;

    assign busy   = (left_q != '0);
    assign accept = wr_req && !busy;
    assign apply  = (left_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (accept) begin
            left_q <= CW'(SYNC_CYC);
        end else if (busy) begin
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
    import wdt_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_apply,
    input  logic [31:0] key_val,
    output logic        run_en
);
    kstate_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (key_apply) begin
            unique case (state_q)
                KS_RUN:   state_d = (key_val == KEY_STOP1) ? KS_ARMED : KS_RUN;
                KS_ARMED: state_d = (key_val == KEY_STOP2) ? KS_HALT  : KS_RUN;
                KS_HALT:  state_d = (key_val == KEY_GO1)   ? KS_REARM : KS_HALT;
                KS_REARM: state_d = (key_val == KEY_GO2)   ? KS_RUN   : KS_HALT;
                default:  state_d = KS_RUN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            KS_RUN, KS_ARMED: run_en = 1'b1;
            default:          run_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int          CNT_W     = 32,
    parameter int          DIV       = 2,
    parameter int          RST_CYC   = 16,
    parameter logic [31:0] LOAD_INIT = 32'hFFFF_FF00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire_out
);
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int PCW = $clog2(RST_CYC + 1);

    logic [PW-1:0]  pre_q;
    logic [PCW-1:0] pulse_q;
    logic           tick, wrap;

    assign tick       = run_en && (pre_q == PW'(DIV - 1));
    assign wrap       = tick && !reload && (cnt == '1);
    assign expire_out = (pulse_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= CNT_W'(LOAD_INIT);
            pre_q <= '0;
        end else if (reload) begin
            cnt   <= load_val;
            pre_q <= '0;
        end else if (run_en) begin
            if (tick) begin
                pre_q <= '0;
                cnt   <= wrap ? load_val : cnt + CNT_W'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pulse_q <= '0;
        else if (wrap)             pulse_q <= PCW'(RST_CYC);
        else if (pulse_q != '0)    pulse_q <= pulse_q - PCW'(1);
    end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int          DIV       = 2,
    parameter int          SYNC_CYC  = 3,
    parameter int          RST_CYC   = 16,
    parameter logic [31:0] LOAD_INIT = 32'hFFFF_FF00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sys_rst_out
);
    localparam int DW = 32;

    logic [DW-1:0] load_q, ctrl_q, cnt_q;
    logic ctrl_acc, ctrl_busy, ctrl_apply;
    logic trig_acc, trig_busy, trig_apply;
    logic run_en;

    wdt_post #(.SYNC_CYC(SYNC_CYC)) u_ctrl_post (
        .clk(clk), .rst_n(rst_n),
        .wr_req(bus_wr && bus_addr == A_CTRL),
        .accept(ctrl_acc), .busy(ctrl_busy), .apply(ctrl_apply)
    );

    wdt_post #(.SYNC_CYC(SYNC_CYC)) u_trig_post (
        .clk(clk), .rst_n(rst_n),
        .wr_req(bus_wr && bus_addr == A_TRIG),
        .accept(trig_acc), .busy(trig_busy), .apply(trig_apply)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= LOAD_INIT;
            ctrl_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_LOAD) load_q <= bus_wdata;
            if (ctrl_acc)                     ctrl_q <= bus_wdata;
        end
    end

    wdt_keyfsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .key_apply(ctrl_apply), .key_val(ctrl_q), .run_en(run_en)
    );

    wdt_counter #(
        .CNT_W(DW), .DIV(DIV), .RST_CYC(RST_CYC), .LOAD_INIT(LOAD_INIT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .reload(trig_apply), .load_val(load_q),
        .cnt(cnt_q), .expire_out(sys_rst_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT: bus_rdata = cnt_q;
            A_LOAD:  bus_rdata = load_q;
            A_CTRL:  bus_rdata = ctrl_q;
            A_PEND: begin
                bus_rdata[PEND_CTRL_BIT] = ctrl_busy;
                bus_rdata[PEND_TRIG_BIT] = trig_busy;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int SYNC_CYC = 3,
    parameter int RST_CYC  = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sys_rst_out,
    input logic        run_en,
    input logic [31:0] cnt_q,
    input logic [31:0] ctrl_q,
    input logic        ctrl_apply,
    input logic        ctrl_busy,
    input logic        trig_apply,
    input logic        bus_wr,
    input logic [7:0]  bus_addr
);
    int hi_cnt, busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= 0;
            busy_cnt <= 0;
        end else begin
            hi_cnt   <= sys_rst_out ? hi_cnt + 1 : 0;
            busy_cnt <= ctrl_busy ? busy_cnt + 1 : 0;
        end
    end

    // R2: pulse never longer than RST_CYC, and ends exactly at RST_CYC
    assert_pulse_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_out |-> hi_cnt < RST_CYC);
    assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_out) |-> hi_cnt == RST_CYC);

    // R3: control pending bit lasts exactly SYNC_CYC
    assert_pend_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_busy |-> busy_cnt < SYNC_CYC);
    assert_pend_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_busy) |-> busy_cnt == SYNC_CYC);

    // R4: write during pending leaves readback alone
    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && ctrl_busy) |=> $stable(ctrl_q));

    // R5: halted counter holds unless a reload lands
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !trig_apply) |=> $stable(cnt_q));

    // R6: counting stops only on an applied second stop key
    assert_stop_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |-> $past(ctrl_apply && ctrl_q == KEY_STOP2));

    // R7: counting resumes only on an applied second restart key
    assert_go_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> $past(ctrl_apply && ctrl_q == KEY_GO2));
endmodule

bind wdt_keyed_top wdt_keyed_chk #(.SYNC_CYC(SYNC_CYC), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_rst_out(sys_rst_out), .run_en(run_en),
    .cnt_q(cnt_q), .ctrl_q(ctrl_q), .ctrl_apply(ctrl_apply),
    .ctrl_busy(ctrl_busy), .trig_apply(trig_apply),
    .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/sim_wdt_keyed_top.sv
`timescale 1ns/1ps
module sim_wdt_keyed_top;
    localparam logic [31:0] INIT = 32'hFFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h28;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_out;

    always #10 clk = ~clk;

    wdt_keyed_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_out(sys_rst_out)
    );

    // behavioural reference model
    int          m_state;   // 0 run, 1 armed, 2 halt, 3 rearm
    logic [31:0] m_cnt, m_load, m_ctrl;
    int          m_pre, m_cbusy, m_tbusy, m_pulse;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = INIT; m_load = INIT; m_ctrl = 0;
            m_pre = 0; m_cbusy = 0; m_tbusy = 0; m_pulse = 0;
        end else begin
            automatic int          o_state = m_state;
            automatic logic [31:0] o_load  = m_load;
            automatic logic [31:0] o_ctrl  = m_ctrl;
            automatic bit c_apply = (m_cbusy == 1);
            automatic bit t_apply = (m_tbusy == 1);
            automatic bit running = (o_state < 2);
            automatic bit wrapped = 0;
            if (bus_wr && bus_addr == 8'h48 && m_cbusy == 0) begin
                m_ctrl = bus_wdata; m_cbusy = 3;
            end else if (m_cbusy > 0) m_cbusy--;
            if (bus_wr && bus_addr == 8'h30 && m_tbusy == 0) m_tbusy = 3;
            else if (m_tbusy > 0) m_tbusy--;
            if (bus_wr && bus_addr == 8'h2C) m_load = bus_wdata;
            if (c_apply) begin
                case (o_state)
                    0: m_state = (o_ctrl == 32'hAAAA) ? 1 : 0;
                    1: m_state = (o_ctrl == 32'h5555) ? 2 : 0;
                    2: m_state = (o_ctrl == 32'hBBBB) ? 3 : 2;
                    default: m_state = (o_ctrl == 32'h4444) ? 0 : 2;
                endcase
            end
            if (t_apply) begin
                m_cnt = o_load; m_pre = 0;
            end else if (running) begin
                if (m_pre == 1) begin
                    m_pre = 0;
                    if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = o_load; wrapped = 1; end
                    else m_cnt = m_cnt + 1;
                end else m_pre++;
            end
            if (wrapped) m_pulse = 16;
            else if (m_pulse > 0) m_pulse--;
        end
    end

    int    n_cmp = 0, n_bad = 0, n_cyc = 0;
    int    n_pulse_seen = 0;
    string cur_req = "R1";
    bit    done = 0;

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h48: return m_ctrl;
            8'h34: return {27'b0, m_cbusy != 0, m_tbusy != 0, 3'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check();
        logic [31:0] e;
        e = exp_rdata(bus_addr);
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, e);
        end
        n_cmp++;
        if (sys_rst_out !== (m_pulse != 0)) begin
            n_bad++;
            $display("FAIL %s sys_rst_out actual=%b expected=%b", cur_req, sys_rst_out, m_pulse != 0);
        end
        if (sys_rst_out) n_pulse_seen++;
    endtask

    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        n_cyc++;
        if (rst_n) check();
        bus_addr = a; bus_wr = w; bus_wdata = d;
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic expect_pulses(input int want);
        n_cmp++;
        if (n_pulse_seen != want) begin
            n_bad++;
            $display("FAIL %s pulse cycles actual=%0d expected=%0d", cur_req, n_pulse_seen, want);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register
        cur_req = "R1";
        idle(1, 8'h28); idle(1, 8'h2C); idle(1, 8'h48); idle(1, 8'h34);
        // R9: unmapped address reads zero
        cur_req = "R9";
        idle(2, 8'h10);
        // R2: run into overflow from reset, observe the full pulse
        cur_req = "R2";
        n_pulse_seen = 0;
        idle(560, 8'h28);
        expect_pulses(16);
        // R8: trigger reload with pending bit 3
        cur_req = "R8";
        wr(8'h30, 32'h1234);
        idle(5, 8'h34);
        idle(10, 8'h28);
        // R4: second key while pending is dropped
        cur_req = "R4";
        wr(8'h48, 32'hAAAA);
        wr(8'h48, 32'h5555);
        idle(4, 8'h48);
        idle(10, 8'h28);
        // R6: wrong value between keys, then stray second key
        cur_req = "R6";
        wr(8'h48, 32'h1111); idle(4, 8'h34);
        wr(8'h48, 32'h5555); idle(4, 8'h34);
        idle(10, 8'h28);
        // R3 and R10: ordered stop pair with polling
        cur_req = "R3";
        wr(8'h48, 32'hAAAA); idle(4, 8'h34);
        cur_req = "R10";
        idle(1, 8'h48);
        cur_req = "R5";
        wr(8'h48, 32'h5555); idle(4, 8'h34);
        n_pulse_seen = 0;
        idle(700, 8'h28);
        expect_pulses(0);
        // R6 while halted: wrong value after first restart key
        cur_req = "R6";
        wr(8'h48, 32'hBBBB); idle(4, 8'h34);
        wr(8'h48, 32'h0000); idle(4, 8'h34);
        wr(8'h48, 32'h4444); idle(4, 8'h34);
        idle(20, 8'h28);
        // R7: restart from held count
        cur_req = "R7";
        wr(8'h48, 32'hBBBB); idle(4, 8'h34);
        wr(8'h48, 32'h4444); idle(4, 8'h34);
        idle(30, 8'h28);
        // R9: load write then trigger gives a short period
        cur_req = "R9";
        wr(8'h2C, 32'hFFFF_FFF0); idle(2, 8'h2C);
        cur_req = "R8";
        wr(8'h30, 32'h0); idle(4, 8'h34);
        cur_req = "R2";
        n_pulse_seen = 0;
        idle(60, 8'h28);
        expect_pulses(16);
        idle(20, 8'h28);
        done = 1;
        summary();
    end
endmodule